// File: doc/BRIEF.md
# PHY Control-Port Handshake Sequencer

This block is a hardware master for the narrow control-register port of a serial PHY. A host issues one high-level command at a time: capture an address, write a register, read a register, run the PHY reset-and-lock sequence, or latch the power-down output. The block turns each command into a series of strobe handshakes on the port. Every strobe is raised, held until the acknowledge line is seen high, dropped, and then the acknowledge must be seen low before the next step begins.

All waits are bounded. Acknowledge is sampled every `pollGap + 1` clock cycles, with at most `POLL_LIMIT` samples per edge. The reset sequence sends the reset bit to the PHY clock/reset register without waiting for an answer, because a PHY in reset cannot reply. It then polls a lane status register, at most `LOCK_LIMIT` times, until the receive-PLL bit is set. A command that runs out of polls ends with an error and leaves every strobe low.

Top module: `phyPortSeq`

## Requirements
- R1: After reset, busy, done, error, phyPowerDown and all four strobes are low and crDataIn is zero.
- R2: At most one of crCapAddr, crCapData, crWrite, crRead is high in any cycle, and crDataIn does not change while a strobe stays high.
- R3: Every step loads crDataIn one cycle before it raises its strobe. The strobe stays high until the synchronized acknowledge is seen high. The next strobe rises only after acknowledge has been seen low.
- R4: cmdOp 3'd1 (write) runs a capture-address handshake with cmdAddr, then a capture-data handshake with cmdData, then a write handshake, and then pulses done.
- R5: cmdOp 3'd2 (read) runs a capture-address handshake, then a read handshake. rdData takes crDataOut while crRead is still high, and done pulses at the end.
- R6: cmdOp 3'd0 runs only a capture-address handshake with cmdAddr and then pulses done.
- R7: If acknowledge is not high after POLL_LIMIT polls spaced pollGap+1 cycles apart, error pulses, all strobes drop and the block returns to idle.
- R8: The same bounded wait and error apply when acknowledge fails to return low after a strobe drops.
- R9: A write to address 0x7F3F with bit 0 of the value set raises crWrite for exactly one cycle with no acknowledge wait and then pulses done.
- R10: cmdOp 3'd3 writes 1 to 0x7F3F as in R9. It then repeats a wait of pollGap+1 cycles, an address capture of 0x2003 and a read, and pulses done once a read value has bit 1 set.
- R11: If LOCK_LIMIT reads in the R10 loop never show bit 1, the command ends with error.
- R12: cmdOp 3'd4 sets phyPowerDown and pulses done one cycle later. phyPowerDown stays high until rst.
- R13: A command is accepted only while busy is low. busy stays high until the cycle in which a one-cycle done or error pulse appears, and cmdValid while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdValid | input | 1 | Command request, sampled while idle |
| cmdOp | input | 3 | Command code (0 addr, 1 write, 2 read, 3 PHY reset, 4 power-down) |
| cmdAddr | input | 16 | Register address for the command |
| cmdData | input | 16 | Value for a write |
| pollGap | input | 16 | Cycles between acknowledge samples, minus one |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse on success |
| error | output | 1 | One-cycle pulse on timeout |
| rdData | output | 16 | Last value sampled from crDataOut |
| crDataIn | output | 16 | Address or data presented to the PHY port |
| crCapAddr | output | 1 | Capture-address strobe |
| crCapData | output | 1 | Capture-data strobe |
| crWrite | output | 1 | Write strobe |
| crRead | output | 1 | Read strobe |
| crAck | input | 1 | Asynchronous acknowledge from the PHY |
| crDataOut | input | 16 | Read data from the PHY |
| phyPowerDown | output | 1 | Sticky power-down control |

## Verification
The bench drives the block against a responder that answers strobes after a short delay and holds a small register file. Writes and reads to two different addresses with distinct values show that address and data reach the port in the right order. An address-only command shows that no data, write or read step follows it. Three fault modes are used: a responder that never acknowledges, one whose acknowledge never falls, and one whose PLL never locks. Each shows that the matching bounded wait ends in an error. A PLL that locks on the third status read shows that the loop stops as soon as bit 1 is seen.

// File: rtl/phyPortPkg.sv
package phyPortPkg;
  typedef enum logic [2:0] {
    OP_ADDR   = 3'd0,
    OP_WRITE  = 3'd1,
    OP_READ   = 3'd2,
    OP_PHYRST = 3'd3,
    OP_PWRDN  = 3'd4
  } opT;

  typedef enum logic [1:0] {STB_ADDR = 2'd0, STB_DATA = 2'd1, STB_WRITE = 2'd2, STB_READ = 2'd3} stbT;

  typedef enum logic [2:0] {
    SRC_CMDADDR, SRC_CMDDATA, SRC_RSTADDR, SRC_RSTVAL, SRC_LOCKADDR
  } srcT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_RAISE, ST_RISE, ST_FALL, ST_FIRE, ST_GAP
  } stateT;

  typedef struct packed {
    logic latchCmd;
    logic loadImage;
    srcT  src;
    logic strobeOn;
    stbT  which;
    logic dropStrobe;
    logic startTimer;
    logic captureRd;
    logic setPwrDn;
  } ctlT;
endpackage

// File: rtl/phyPortData.sv
module phyPortData
  import phyPortPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int GAP_W = 16,
  parameter int LOCK_BIT = 1,
  parameter logic [DATA_W-1:0] RST_ADDR = 16'h7F3F,
  parameter logic [DATA_W-1:0] LOCK_ADDR = 16'h2003
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlT               ctl,
  input  logic [DATA_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [GAP_W-1:0]  pollGap,
  input  logic              ackAsync,
  input  logic [DATA_W-1:0] phyDataOut,
  output logic [DATA_W-1:0] dataIn,
  output logic [3:0]        strobes,
  output logic              ackSync,
  output logic              timerZero,
  output logic              lockSeen,
  output logic              fireHit,
  output logic [DATA_W-1:0] rdData,
  output logic              pwrDn
);
  logic [DATA_W-1:0] addrQ, dataQ, srcVal;
  logic [GAP_W-1:0]  timerQ;
  logic              ackMeta;

  always_comb begin
    case (ctl.src)
      SRC_CMDADDR:  srcVal = addrQ;
      SRC_CMDDATA:  srcVal = dataQ;
      SRC_RSTADDR:  srcVal = RST_ADDR;
      SRC_RSTVAL:   srcVal = DATA_W'(1);
      SRC_LOCKADDR: srcVal = LOCK_ADDR;
      default:      srcVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ   <= '0;
      dataQ   <= '0;
      dataIn  <= '0;
      strobes <= '0;
      ackMeta <= 1'b0;
      ackSync <= 1'b0;
      timerQ  <= '0;
      rdData  <= '0;
      pwrDn   <= 1'b0;
    end else begin
      ackMeta <= ackAsync;
      ackSync <= ackMeta;
      if (ctl.latchCmd) begin
        addrQ <= cmdAddr;
        dataQ <= cmdData;
      end
      if (ctl.loadImage) begin
        dataIn  <= srcVal;
        strobes <= '0;
      end else if (ctl.strobeOn) begin
        strobes <= 4'(1) << ctl.which;
      end else if (ctl.dropStrobe) begin
        strobes <= '0;
      end
      if (ctl.startTimer) timerQ <= pollGap;
      else if (timerQ != '0) timerQ <= timerQ - 1'b1;
      if (ctl.captureRd) rdData <= phyDataOut;
      if (ctl.setPwrDn) pwrDn <= 1'b1;
    end
  end

  assign timerZero = (timerQ == '0);
  assign lockSeen  = rdData[LOCK_BIT];
  assign fireHit   = (addrQ == RST_ADDR) && dataQ[0];

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst) $onehot0(strobes));
  assert_data_hold_R2: assert property (@(posedge clk) disable iff (rst)
    ((|strobes) && $past(|strobes)) |-> $stable(dataIn));
  assert_read_capture_R5: assert property (@(posedge clk) disable iff (rst)
    ctl.captureRd |-> strobes[STB_READ]);
  assert_pwrdn_sticky_R12: assert property (@(posedge clk) disable iff (rst) pwrDn |=> pwrDn);
endmodule

// File: rtl/phyPortCtrl.sv
module phyPortCtrl
  import phyPortPkg::*;
#(
  parameter int POLL_LIMIT = 10,
  parameter int LOCK_LIMIT = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       ackSync,
  input  logic       timerZero,
  input  logic       lockSeen,
  input  logic       fireHit,
  output ctlT        ctl,
  output logic       busy,
  output logic       done,
  output logic       error
);
  localparam int POLL_CW = $clog2(POLL_LIMIT + 1);
  localparam int LOCK_CW = $clog2(LOCK_LIMIT + 1);
  localparam logic [POLL_CW-1:0] POLL_LAST = POLL_CW'(POLL_LIMIT - 1);
  localparam logic [LOCK_CW-1:0] LOCK_LAST = LOCK_CW'(LOCK_LIMIT - 1);

  stateT state, stateN;
  opT    op, opN;
  stbT   step, stepN;
  logic  phase, phaseN, finish, fail;
  logic [POLL_CW-1:0] pollCnt, pollN;
  logic [LOCK_CW-1:0] lockCnt, lockN;

  always_comb begin
    ctl = '0;
    stateN = state; opN = op; stepN = step; phaseN = phase;
    pollN = pollCnt; lockN = lockCnt;
    finish = 1'b0; fail = 1'b0;
    if (step == STB_ADDR)
      ctl.src = (op == OP_PHYRST) ? (phase ? SRC_LOCKADDR : SRC_RSTADDR) : SRC_CMDADDR;
    else
      ctl.src = (op == OP_PHYRST) ? SRC_RSTVAL : SRC_CMDDATA;
    ctl.which = step;
    case (state)
      ST_IDLE: if (cmdValid) begin
        case (cmdOp)
          OP_ADDR, OP_WRITE, OP_READ, OP_PHYRST: begin
            ctl.latchCmd = 1'b1;
            opN = opT'(cmdOp); stepN = STB_ADDR; phaseN = 1'b0;
            stateN = ST_SETUP;
          end
          OP_PWRDN: begin ctl.setPwrDn = 1'b1; finish = 1'b1; end
          default: finish = 1'b1;
        endcase
      end
      ST_SETUP: begin ctl.loadImage = 1'b1; stateN = ST_RAISE; end
      ST_RAISE: begin
        ctl.strobeOn = 1'b1; ctl.startTimer = 1'b1; pollN = '0; stateN = ST_RISE;
      end
      ST_RISE: if (timerZero) begin
        if (ackSync) begin
          ctl.dropStrobe = 1'b1; ctl.captureRd = (step == STB_READ);
          ctl.startTimer = 1'b1; pollN = '0; stateN = ST_FALL;
        end else if (pollCnt == POLL_LAST) fail = 1'b1;
        else begin pollN = pollCnt + 1'b1; ctl.startTimer = 1'b1; end
      end
      ST_FALL: if (timerZero) begin
        if (!ackSync) begin
          case (step)
            STB_ADDR:
              if (op == OP_ADDR) finish = 1'b1;
              else if (op == OP_WRITE || (op == OP_PHYRST && !phase)) begin
                stepN = STB_DATA; stateN = ST_SETUP;
              end else begin stepN = STB_READ; stateN = ST_RAISE; end
            STB_DATA:
              if (op == OP_PHYRST || fireHit) begin
                ctl.strobeOn = 1'b1; ctl.which = STB_WRITE; stateN = ST_FIRE;
              end else begin stepN = STB_WRITE; stateN = ST_RAISE; end
            STB_WRITE: finish = 1'b1;
            default:
              if (op != OP_PHYRST || lockSeen) finish = 1'b1;
              else if (lockCnt == LOCK_LAST) fail = 1'b1;
              else begin lockN = lockCnt + 1'b1; ctl.startTimer = 1'b1; stateN = ST_GAP; end
          endcase
        end else if (pollCnt == POLL_LAST) fail = 1'b1;
        else begin pollN = pollCnt + 1'b1; ctl.startTimer = 1'b1; end
      end
      ST_FIRE: begin
        ctl.dropStrobe = 1'b1;
        if (op == OP_PHYRST) begin
          phaseN = 1'b1; lockN = '0; ctl.startTimer = 1'b1; stateN = ST_GAP;
        end else finish = 1'b1;
      end
      ST_GAP: if (timerZero) begin stepN = STB_ADDR; stateN = ST_SETUP; end
      default: stateN = ST_IDLE;
    endcase
    if (finish || fail) begin ctl.dropStrobe = 1'b1; stateN = ST_IDLE; end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; op <= OP_ADDR; step <= STB_ADDR; phase <= 1'b0;
      pollCnt <= '0; lockCnt <= '0; done <= 1'b0; error <= 1'b0;
    end else begin
      state <= stateN; op <= opN; step <= stepN; phase <= phaseN;
      pollCnt <= pollN; lockCnt <= lockN; done <= finish; error <= fail;
    end
  end

  assign busy = (state != ST_IDLE);

  assert_pulse_excl_R13: assert property (@(posedge clk) disable iff (rst) !(done && error));
  assert_idle_on_end_R13: assert property (@(posedge clk) disable iff (rst) (done || error) |-> !busy);
  assert_poll_bound_R7: assert property (@(posedge clk) disable iff (rst) pollCnt <= POLL_LAST);
  assert_lock_bound_R11: assert property (@(posedge clk) disable iff (rst) lockCnt <= LOCK_LAST);
endmodule

// File: rtl/phyPortSeq.sv
module phyPortSeq
  import phyPortPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int GAP_W = 16,
  parameter int POLL_LIMIT = 10,
  parameter int LOCK_LIMIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [GAP_W-1:0]  pollGap,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] crDataIn,
  output logic              crCapAddr,
  output logic              crCapData,
  output logic              crWrite,
  output logic              crRead,
  input  logic              crAck,
  input  logic [DATA_W-1:0] crDataOut,
  output logic              phyPowerDown
);
  ctlT        ctl;
  logic [3:0] strobes;
  logic       ackSync, timerZero, lockSeen, fireHit;

  phyPortCtrl #(.POLL_LIMIT(POLL_LIMIT), .LOCK_LIMIT(LOCK_LIMIT)) uCtrl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .ackSync(ackSync),
    .timerZero(timerZero), .lockSeen(lockSeen), .fireHit(fireHit), .ctl(ctl),
    .busy(busy), .done(done), .error(error)
  );

  phyPortData #(.DATA_W(DATA_W), .GAP_W(GAP_W)) uData (
    .clk(clk), .rst(rst), .ctl(ctl), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .pollGap(pollGap), .ackAsync(crAck), .phyDataOut(crDataOut), .dataIn(crDataIn),
    .strobes(strobes), .ackSync(ackSync), .timerZero(timerZero), .lockSeen(lockSeen),
    .fireHit(fireHit), .rdData(rdData), .pwrDn(phyPowerDown)
  );

  assign crCapAddr = strobes[STB_ADDR];
  assign crCapData = strobes[STB_DATA];
  assign crWrite   = strobes[STB_WRITE];
  assign crRead    = strobes[STB_READ];

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (rst) error |-> (strobes == 4'b0));
endmodule

// File: tb/tb_phyPortSeq.sv
module tb_phyPortSeq;
  logic clk = 1'b0, rst = 1'b1;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [15:0] cmdAddr = '0, cmdData = '0;
  logic [15:0] pollGap = 16'd4;
  logic busy, done, error, crCapAddr, crCapData, crWrite, crRead, phyPowerDown;
  logic [15:0] rdData, crDataIn;
  logic crAck;
  logic [15:0] crDataOut;

  always #10 clk = ~clk;

  phyPortSeq dut (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .pollGap(pollGap), .busy(busy), .done(done), .error(error),
    .rdData(rdData), .crDataIn(crDataIn), .crCapAddr(crCapAddr), .crCapData(crCapData),
    .crWrite(crWrite), .crRead(crRead), .crAck(crAck), .crDataOut(crDataOut),
    .phyPowerDown(phyPowerDown)
  );

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // PHY responder model
  logic [3:0] stb, stbP;
  logic [15:0] dinP, mAddr, mData;
  logic [15:0] mem [int];
  bit deaf = 0, stuck = 0, relax = 0;
  int ackCnt, lockAfter = 3, statusReads, readCount, capAddrCount, wrHigh, lastWrLen, viol;
  assign stb = {crRead, crWrite, crCapData, crCapAddr};

  always @(posedge clk) begin
    if (rst) begin
      crAck <= 1'b0; crDataOut <= '0; stbP <= '0; dinP <= '0; ackCnt <= 0;
      mAddr <= '0; mData <= '0; wrHigh <= 0;
    end else begin
      stbP <= stb; dinP <= crDataIn;
      if ($countones(stb) > 1) viol <= viol + 1;
      if ((|stb) && (|stbP) && crDataIn != dinP) viol <= viol + 1;
      if (((stb & ~stbP) != 0) && crAck && !relax) viol <= viol + 1;
      if (((stbP & ~stb) != 0) && !crAck && !relax &&
          !(stbP == 4'b0100 && mAddr == 16'h7F3F && mData[0])) viol <= viol + 1;
      if (((stuck || ((|stb) && !deaf)) ? 1'b1 : 1'b0) != crAck) begin
        if (ackCnt == 1) begin crAck <= ~crAck; ackCnt <= 0; end
        else ackCnt <= ackCnt + 1;
      end else ackCnt <= 0;
      if (stb[0] && !stbP[0]) begin mAddr <= crDataIn; capAddrCount <= capAddrCount + 1; end
      if (stb[1] && !stbP[1]) mData <= crDataIn;
      if (stb[2] && !stbP[2]) begin
        if (mAddr == 16'h7F3F && mData[0]) statusReads <= 0;
        else mem[int'(mAddr)] = mData;
      end
      if (stb[3] && !stbP[3]) begin
        readCount <= readCount + 1;
        if (mAddr == 16'h2003) begin
          crDataOut <= (statusReads + 1 >= lockAfter) ? 16'h0002 : 16'h0000;
          statusReads <= statusReads + 1;
        end else crDataOut <= mem.exists(int'(mAddr)) ? mem[int'(mAddr)] : 16'h0000;
      end
      if (stb[2]) wrHigh <= wrHigh + 1; else wrHigh <= 0;
      if (stbP[2] && !stb[2]) lastWrLen <= wrHigh;
    end
  end

  // Scoreboard
  typedef struct { bit isErr; bit chkData; logic [15:0] data; string req; } expT;
  expT sbq[$];
  int endCyc;

  always @(negedge clk) begin
    expT e;
    if (!rst && (done || error)) begin
      endCyc = cyc;
      if (sbq.size() == 0) check(1'b0, "R13 unexpected pulse", {done, error}, 0);
      else begin
        e = sbq.pop_front();
        check(error == e.isErr, {e.req, " outcome"}, error, e.isErr);
        if (e.chkData) check(rdData == e.data, {e.req, " rdData"}, rdData, e.data);
      end
    end
  end

  int accCyc;
  task automatic runCmd(input logic [2:0] op, input logic [15:0] a, input logic [15:0] d,
                        input bit isErr, input bit chk, input logic [15:0] expD, input string req);
    expT e;
    e.isErr = isErr; e.chkData = chk; e.data = expD; e.req = req;
    sbq.push_back(e);
    @(negedge clk);
    cmdOp = op; cmdAddr = a; cmdData = d; cmdValid = 1'b1; accCyc = cyc;
    @(negedge clk);
    cmdValid = 1'b0;
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({busy, done, error, phyPowerDown} == 4'b0, "R1 flags", {busy, done, error, phyPowerDown}, 0);
    check(stb == 4'b0 && crDataIn == 16'h0, "R1 port", {stb, crDataIn}, 0);

    runCmd(3'd1, 16'h0010, 16'hBEEF, 0, 0, 0, "R4 write A");
    runCmd(3'd2, 16'h0010, 16'h0000, 0, 1, 16'hBEEF, "R5 read A");
    runCmd(3'd1, 16'h0123, 16'h5A5A, 0, 0, 0, "R4 write B");
    runCmd(3'd2, 16'h0123, 16'h0000, 0, 1, 16'h5A5A, "R5 read B");

    base = capAddrCount; accCyc = readCount;
    begin
      int rc;
      rc = readCount;
      runCmd(3'd0, 16'h0456, 16'hFFFF, 0, 0, 0, "R6 addr only");
      check(capAddrCount - base == 1 && readCount == rc, "R6 single step", capAddrCount - base, 1);
      check(mAddr == 16'h0456, "R6 address", mAddr, 16'h0456);
    end

    runCmd(3'd1, 16'h7F3F, 16'h0003, 0, 0, 0, "R9 reset write");
    check(lastWrLen == 1, "R9 pulse width", lastWrLen, 1);

    lockAfter = 3; base = readCount;
    runCmd(3'd3, 16'h0000, 16'h0000, 0, 1, 16'h0002, "R10 lock");
    check(readCount - base == 3, "R10 iterations", readCount - base, 3);

    lockAfter = 100; base = readCount;
    runCmd(3'd3, 16'h0000, 16'h0000, 1, 0, 0, "R11 no lock");
    check(readCount - base == 10, "R11 iterations", readCount - base, 10);

    relax = 1; deaf = 1;
    runCmd(3'd0, 16'h0001, 16'h0000, 1, 0, 0, "R7 no ack");
    check(endCyc - accCyc >= 50 && endCyc - accCyc <= 58, "R7 timeout window", endCyc - accCyc, 53);
    check(stb == 4'b0 && !busy, "R7 quiet", {busy, stb}, 0);
    deaf = 0; stuck = 1;
    runCmd(3'd0, 16'h0002, 16'h0000, 1, 0, 0, "R8 ack stuck");
    check(stb == 4'b0 && !busy, "R8 quiet", {busy, stb}, 0);
    stuck = 0;
    repeat (10) @(negedge clk);
    relax = 0;

    begin
      expT e;
      e.isErr = 0; e.chkData = 0; e.data = 0; e.req = "R13 busy write";
      sbq.push_back(e);
      @(negedge clk);
      cmdOp = 3'd1; cmdAddr = 16'h0300; cmdData = 16'h7777; cmdValid = 1'b1;
      @(negedge clk); cmdValid = 1'b0;
      repeat (4) @(negedge clk);
      check(busy == 1'b1, "R13 busy", busy, 1);
      cmdOp = 3'd1; cmdAddr = 16'h0200; cmdData = 16'h1111; cmdValid = 1'b1;
      @(negedge clk); cmdValid = 1'b0;
      while (sbq.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
    end
    runCmd(3'd2, 16'h0200, 16'h0000, 0, 1, 16'h0000, "R13 ignored cmd");
    runCmd(3'd2, 16'h0300, 16'h0000, 0, 1, 16'h7777, "R13 accepted cmd");

    runCmd(3'd4, 16'h0000, 16'h0000, 0, 0, 0, "R12 power down");
    check(phyPowerDown == 1'b1, "R12 set", phyPowerDown, 1);
    lockAfter = 1;
    runCmd(3'd3, 16'h0000, 16'h0000, 0, 1, 16'h0002, "R12 reset seq");
    check(phyPowerDown == 1'b1, "R12 sticky", phyPowerDown, 1);

    check(viol == 0, "R2 R3 protocol", viol, 0);

    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(phyPowerDown == 1'b0, "R12 cleared by reset", phyPowerDown, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule